// File: doc/BRIEF.md
# Bank-Gated Low-Power Memory Array

This block is a single-port synchronous memory of 2048 words by 36 bits. It is split by depth into four banks of 512 words. Each bank stores whole words. The upper address bits pick one bank, and only that bank is enabled for the access. A read or write therefore switches one quarter of the storage array instead of all of it. When no access is requested, every bank stays disabled.

A multiplexer returns the word from the bank that served the last read. The bank select that steers it is registered, so it stays aligned with the returned data. A parameter can add one output register after the multiplexer to ease timing, which adds one cycle of read latency. Writes never disturb the read output, so logic downstream of the read port sees no switching while the memory is being written or left idle. The one-hot bank-enable vector is brought out so that enable activity can be observed.

Top module: `banked_sram`

## Requirements
- R1: The array holds 2048 words of 36 bits. A word written at any address is returned by a later read of that address. Address bits [10:9] select the bank and bits [8:0] select the word inside it.
- R2: During an access (`req`=1), exactly one bit of `bank_en` is high, and it is bit number `addr[10:9]`.
- R3: While `req`=0, `bank_en` is all zero.
- R4: Read data appears on `rdata` one clock edge after the read request when `PIPE`=0, and two edges after it when `PIPE`=1.
- R5: A write (`req`=1, `we`=1) leaves `rdata` unchanged. It shows neither the written word nor the old contents, although a read already in the pipeline still completes.
- R6: While idle, `rdata` keeps the value of the last completed read.
- R7: While reset is active and right after it, `rdata` is zero and `bank_en` is zero when no request is made.
- R8: Back-to-back reads that hop between banks each return the word from their own bank, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read (valid with req) |
| addr | input | 11 | Word address; [10:9] bank, [8:0] row |
| wdata | input | 36 | Word to write |
| rdata | output | 36 | Read word, held between reads |
| bank_en | output | 4 | One-hot bank enable for the current access |

## Verification
A write can fall in the same cycle that the result of the previous read is being returned. With the output register enabled, the write cycle is exactly when the pipelined read word lands on `rdata`. The bench provokes this by issuing a read and then, on the next cycle, a write to the same address. It then checks on both a one-cycle and a two-cycle instance that `rdata` carries the pre-write word and keeps it through the write and the following idle cycles. A later read must then return the new word.

// File: rtl/banked_sram.sv
module banked_sram #(
  parameter int WORD_W    = 36,
  parameter int ADDR_W    = 11,
  parameter int BANK_BITS = 2,
  parameter int PIPE      = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [WORD_W-1:0]          wdata,
  output logic [WORD_W-1:0]          rdata,
  output logic [(1<<BANK_BITS)-1:0]  bank_en
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam int ROW_W = ADDR_W - BANK_BITS;
  localparam int ROWS  = 1 << ROW_W;

  wire [BANK_BITS-1:0] bsel = addr[ADDR_W-1 -: BANK_BITS];
  wire [ROW_W-1:0]     row  = addr[ROW_W-1:0];
  wire                 rd   = req && !we;

  logic [WORD_W-1:0]    bank_q [NBANK];
  logic [BANK_BITS-1:0] sel_q;
  logic                 rd_q;
  logic [WORD_W-1:0]    mux_out;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [WORD_W-1:0] mem [ROWS];
    logic [WORD_W-1:0] q;

    assign bank_en[b] = req && (bsel == BANK_BITS'(b));

    always_ff @(posedge clk)
      if (bank_en[b] && we) mem[row] <= wdata;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 q <= '0;
      else if (bank_en[b] && !we) q <= mem[row];

    assign bank_q[b] = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= rd;
      if (rd) sel_q <= bsel;
    end

  assign mux_out = bank_q[sel_q];

  if (PIPE != 0) begin : g_pipe
    logic [WORD_W-1:0] out_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    out_q <= '0;
      else if (rd_q) out_q <= mux_out;
    assign rdata = out_q;

    p_pipe_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_q |=> rdata == $past(mux_out));
  end else begin : g_direct
    assign rdata = mux_out;
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $countones(bank_en) == 1);

  p_idle_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> bank_en == '0);

  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && (PIPE == 0 || !rd_q)) |=> $stable(rdata));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && (PIPE == 0 || !rd_q)) |=> $stable(rdata));
endmodule

// File: tb/sim_banked_sram.sv
`timescale 1ns/1ps
module sim_banked_sram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [10:0] addr;
  logic [35:0] wdata;
  logic [35:0] rdata0, rdata1;
  logic [3:0]  bank_en0, bank_en1;

  always #2.5 clk = ~clk;

  banked_sram #(.PIPE(0)) u0 (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata0), .bank_en(bank_en0));
  banked_sram #(.PIPE(1)) u1 (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata1), .bank_en(bank_en1));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [35:0] model [2048];
  logic [35:0] exp0, exp1;
  bit prev_rd;

  function automatic logic [35:0] pat(input logic [10:0] a, input logic [3:0] s);
    return (36'(a) * 36'h9E3779B1) ^ {s, 32'h5A5A_0F0F} ^ {25'(0), a};
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit r, input bit w, input logic [10:0] a, input logic [35:0] d,
                    input string tag);
    logic [3:0] en;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    #1;
    en = r ? (4'b0001 << a[10:9]) : 4'b0000;
    chk(r ? "R2 bank_en u0" : "R3 bank_en u0", {32'b0, bank_en0}, {32'b0, en});
    chk(r ? "R2 bank_en u1" : "R3 bank_en u1", {32'b0, bank_en1}, {32'b0, en});
    @(posedge clk);
    if (prev_rd) exp1 = exp0;
    if (r && !w) exp0 = model[a];
    if (r && w) model[a] = d;
    prev_rd = r && !w;
    #1;
    chk({tag, " u0"}, rdata0, exp0);
    chk({tag, " u1"}, rdata1, exp1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 rdata u0 in reset", rdata0, 36'h0);
    chk("R7 rdata u1 in reset", rdata1, 36'h0);
    chk("R7 bank_en in reset", {32'b0, bank_en0}, 36'h0);
    @(negedge clk); rst_n = 1'b1;
    exp0 = '0; exp1 = '0; prev_rd = 0;
    op(0, 0, 11'd0, 36'h0, "R7 after reset");
  endtask

  task automatic t_fill;
    for (int a = 0; a < 2048; a++) op(1, 1, 11'(a), pat(11'(a), 4'h3), "R5 fill");
  endtask

  task automatic t_cross_banks;
    op(1, 0, {2'd0, 9'd17}, '0, "R8 bank0");
    op(1, 0, {2'd1, 9'd17}, '0, "R8 bank1");
    op(1, 0, {2'd2, 9'd17}, '0, "R8 bank2");
    op(1, 0, {2'd3, 9'd17}, '0, "R8 bank3");
    op(1, 0, {2'd0, 9'd511}, '0, "R8 bank0 top");
    op(0, 0, 11'd0, '0, "R4 drain");
    op(0, 0, 11'd0, '0, "R4 drain");
  endtask

  task automatic t_read_then_write;
    op(1, 0, 11'h2A5, '0, "R5 read before write");
    op(1, 1, 11'h2A5, 36'hF_0F0F_1234, "R5 write after read");
    op(1, 1, 11'h4C1, 36'hA_5555_AAAA, "R5 second write");
    op(0, 0, 11'd0, '0, "R6 idle after write");
    op(1, 0, 11'h2A5, '0, "R1 read new word");
    op(0, 0, 11'd0, '0, "R4 drain");
  endtask

  task automatic t_idle;
    op(1, 0, 11'h7FF, '0, "R1 last word");
    for (int i = 0; i < 5; i++) op(0, 0, 11'(i * 300), 36'hF_FFFF_FFFF, "R6 idle hold");
  endtask

  task automatic t_random;
    for (int i = 0; i < 600; i++) begin
      bit r, w;
      logic [10:0] a;
      r = ($urandom % 4) != 0;
      w = ($urandom % 3) == 0;
      a = 11'($urandom);
      op(r, w, a, {4'($urandom), 32'($urandom)}, "R1 random");
    end
    op(0, 0, 11'd0, '0, "R4 drain");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_fill;
    t_cross_banks;
    t_read_then_write;
    t_idle;
    t_random;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule